// File: doc/BRIEF.md
# Sleep-Aware ADC Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter inside a microcontroller. Software sets it up through three byte-wide registers: control, configuration and interrupt. The control register holds the clock choice, the channel, the start/busy bit and the power enable. The configuration register holds the result alignment and the pin-function code. The interrupt register holds a completion flag and its enable. After a start, the block samples and then resolves ten bits, most significant first. It does this by presenting a trial code to an external DAC and reading back a one-bit comparator decision. The finished code goes into a pair of result bytes.

Behaviour depends on the power state. With the internal RC conversion clock, a conversion begins only after a short hold-off, so the core can go to sleep first. The conversion then runs to the end during sleep. When it finishes, the block asks for a wake-up if its interrupt is enabled. If the interrupt is disabled, it powers itself down. With any other clock, entering sleep kills the conversion and powers the block down. In every case the enable bit keeps reading 1. There are two resets. A device reset clears every control field. A power-on reset also clears the result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After any reset, the control, configuration and interrupt registers read 0x00, `powered` and `wake` are low, and no conversion runs. Port-config code 0 means that all converter pins are analog.
- R2: Asserting `rst_n` alone leaves the result bytes unchanged. Asserting `por_n` clears the stored result to zero.
- R3: A write of 1 to the go bit (control bit 2) is ignored unless the enable bit (control bit 0) already read 1 before that write. Go then reads 0 and the result does not change.
- R4: A conversion takes 11 conversion-clock ticks: one sample tick and ten decision ticks, most significant bit first. The clock select is control bits [7:6]. Code 00 gives a tick every 2 clocks, 01 every 8 clocks and 10 every 32 clocks. When the code is known, go clears and the flag (interrupt bit 0) sets in the same cycle. The result holds the comparator decisions.
- R5: Configuration bit 7 set means the result is right-aligned: high byte = {6'b0, code[9:8]}, low byte = code[7:0]. Bit 7 clear means it is left-aligned: high byte = code[9:2], low byte = {code[1:0], 6'b0}.
- R6: With clock select 11 (RC), the sequencer waits 4 clocks after the go write before sampling. It then uses `rc_tick` pulses as conversion ticks.
- R7: While enabled with a non-RC clock, a sleep request aborts any conversion. Go reads 0, no flag is set, the result is unchanged and `powered` drops, while the enable bit still reads 1. `powered` returns when sleep ends.
- R8: An RC conversion started before sleep completes during sleep. With the interrupt enable (interrupt bit 1) set, the block stays powered and `wake` goes high.
- R9: An RC conversion that completes during sleep with the interrupt enable clear powers the block down. The enable bit stays 1 and `wake` stays low.
- R10: Writing the control register with go or enable at 0 during a conversion aborts it. No flag is set and the result is unchanged.
- R11: Writing the interrupt register (select 2) loads the flag from bit 0 and the enable from bit 1. `wake` equals sleep request AND flag AND enable. Select 0 writes control, select 1 writes configuration and select 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Device reset (pin or watchdog), active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 configuration, 2 interrupt |
| wr_data | input | 8 | Write data |
| sleep_req | input | 1 | Core is in sleep |
| rc_tick | input | 1 | One-cycle pulse from the internal RC conversion clock |
| cmp_bit | input | 1 | Comparator decision: 1 keeps the trial bit |
| ctrl_q | output | 8 | Control readback {clk sel[1:0], channel[2:0], go, 0, enable} |
| cfg_q | output | 8 | Configuration readback {right-align, 3'b0, port code[3:0]} |
| irq_q | output | 8 | Interrupt readback {6'b0, enable, flag} |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |
| dac_code | output | 10 | Trial code to the DAC, zero outside decisions |
| chan_sel | output | 3 | Selected input channel |
| powered | output | 1 | Converter analog section is on |
| wake | output | 1 | Wake-up request to the core |

## Verification
A wrong phase or bit index in the sequencer shows up on `dac_code` within one conversion tick. It also moves the cycle in which go clears and the flag rises, or it corrupts the result bytes. The bench compares all of these on every clock, so a timing slip of a single clock is reported at that clock. A wrong power-down or wake decision shows at `powered` and `wake` one clock after the sleep edge or after completion. A result register that loses state shows at the result bytes right after the reset pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_SAMP = 2'd2,
    PH_CONV = 2'd3
  } phase_e;

  localparam logic [1:0] CLK_RC   = 2'b11;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CFG  = 2'd1;
  localparam logic [1:0] SEL_IRQ  = 2'd2;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
  import adc_seq_pkg::*;
#(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  input  logic       rc_tick,
  output logic       tick
);
  localparam int CW = $clog2(DIV_C + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (sel)
      2'b00:   lim = CW'(DIV_A);
      2'b01:   lim = CW'(DIV_B);
      default: lim = CW'(DIV_C);
    endcase
    if (sel == CLK_RC) tick = run & rc_tick;
    else               tick = run & (cnt_q >= lim - 1'b1);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> cnt_q == '0);
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
  import adc_seq_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int HOLD_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rc_mode,
  input  logic             abort,
  input  logic             tick,
  input  logic             cmp_bit,
  output logic             run,
  output logic             done,
  output logic [RES_W-1:0] done_code,
  output logic [RES_W-1:0] dac_code
);
  localparam int IW = $clog2(RES_W);
  localparam int HW = $clog2(HOLD_CLKS + 1);

  phase_e           phase_q, phase_d;
  logic [HW-1:0]    hold_q, hold_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [RES_W-1:0] sar_q, sar_d, mask, trial;

  always_comb begin
    mask      = {{(RES_W-1){1'b0}}, 1'b1} << idx_q;
    trial     = sar_q | mask;
    done_code = cmp_bit ? trial : sar_q;
    done      = (phase_q == PH_CONV) && tick && (idx_q == '0) && !abort;
    run       = (phase_q == PH_SAMP) || (phase_q == PH_CONV);
    dac_code  = (phase_q == PH_CONV) ? trial : '0;
    phase_d   = phase_q;
    hold_d    = hold_q;
    idx_d     = idx_q;
    sar_d     = sar_q;
    if (abort) begin
      phase_d = PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_d = rc_mode ? PH_HOLD : PH_SAMP;
          hold_d  = '0;
        end
        PH_HOLD: begin
          if (hold_q == HW'(HOLD_CLKS - 1)) phase_d = PH_SAMP;
          else                              hold_d  = hold_q + 1'b1;
        end
        PH_SAMP: if (tick) begin
          phase_d = PH_CONV;
          idx_d   = IW'(RES_W - 1);
          sar_d   = '0;
        end
        default: if (tick) begin
          sar_d = done_code;
          if (idx_q == '0) phase_d = PH_IDLE;
          else             idx_d   = idx_q - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      hold_q  <= '0;
      idx_q   <= '0;
      sar_q   <= '0;
    end else begin
      phase_q <= phase_d;
      hold_q  <= hold_d;
      idx_q   <= idx_d;
      sar_q   <= sar_d;
    end
  end

  // R4
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CONV && tick && !abort && idx_q != '0)
      |=> idx_q == $past(idx_q) - IW'(1));
  // R6
  rc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && start && rc_mode && !abort) |=> phase_q == PH_HOLD);
  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> phase_q == PH_IDLE);
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              right_just,
  input  logic [RES_W-1:0]  code,
  output logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] lo
);
  localparam int PAD = 2 * BYTE_W - RES_W;

  logic [2*BYTE_W-1:0] word;

  always_comb begin
    if (right_just) word = {{PAD{1'b0}}, code};
    else            word = {code, {PAD{1'b0}}};
    hi = word[2*BYTE_W-1:BYTE_W];
    lo = word[BYTE_W-1:0];
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int DIV_A     = 2,
  parameter int DIV_B     = 8,
  parameter int DIV_C     = 32,
  parameter int HOLD_CLKS = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             sleep_req,
  input  logic             rc_tick,
  input  logic             cmp_bit,
  output logic [7:0]       ctrl_q,
  output logic [7:0]       cfg_q,
  output logic [7:0]       irq_q,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo,
  output logic [RES_W-1:0] dac_code,
  output logic [2:0]       chan_sel,
  output logic             powered,
  output logic             wake
);
  localparam int PAD = 16 - RES_W;

  logic dev_rst_n, por_rst_n;
  logic [1:0] cs_q, cs_d;
  logic [2:0] chs_q, chs_d;
  logic [3:0] pcfg_q, pcfg_d;
  logic go_q, go_d, en_q, en_d, just_q, just_d;
  logic flag_q, flag_d, ie_q, ie_d, off_q, off_d;
  logic [RES_W-1:0] result_q, done_code;
  logic ctrl_wr, cfg_wr, irq_wr, sleep_kill, go_req, user_abort;
  logic tick, run, done;

  adc_rst_sync u_dev_sync (.clk(clk), .arst_n(por_n & rst_n), .srst_n(dev_rst_n));
  adc_rst_sync u_por_sync (.clk(clk), .arst_n(por_n),         .srst_n(por_rst_n));

  always_comb begin
    ctrl_wr    = wr_en && (wr_sel == SEL_CTRL);
    cfg_wr     = wr_en && (wr_sel == SEL_CFG);
    irq_wr     = wr_en && (wr_sel == SEL_IRQ);
    sleep_kill = sleep_req && en_q && (cs_q != CLK_RC);
    go_req     = ctrl_wr && wr_data[2] && wr_data[0] && en_q && !off_q
                 && !go_q && !sleep_req;
    user_abort = go_q && ctrl_wr && !(wr_data[2] && wr_data[0]);

    cs_d   = ctrl_wr ? wr_data[7:6] : cs_q;
    chs_d  = ctrl_wr ? wr_data[5:3] : chs_q;
    en_d   = ctrl_wr ? wr_data[0]   : en_q;
    just_d = cfg_wr  ? wr_data[7]   : just_q;
    pcfg_d = cfg_wr  ? wr_data[3:0] : pcfg_q;
    ie_d   = irq_wr  ? wr_data[1]   : ie_q;

    if (sleep_kill || user_abort || done) go_d = 1'b0;
    else if (go_req)                      go_d = 1'b1;
    else                                  go_d = go_q;

    if (done)        flag_d = 1'b1;
    else if (irq_wr) flag_d = wr_data[0];
    else             flag_d = flag_q;

    if (sleep_kill)         off_d = 1'b1;
    else if (!sleep_req)    off_d = 1'b0;
    else if (done && !ie_q) off_d = 1'b1;
    else                    off_d = off_q;
  end

  always_ff @(posedge clk or negedge dev_rst_n) begin
    if (!dev_rst_n) begin
      cs_q   <= '0;
      chs_q  <= '0;
      go_q   <= 1'b0;
      en_q   <= 1'b0;
      just_q <= 1'b0;
      pcfg_q <= '0;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      off_q  <= 1'b0;
    end else begin
      cs_q   <= cs_d;
      chs_q  <= chs_d;
      go_q   <= go_d;
      en_q   <= en_d;
      just_q <= just_d;
      pcfg_q <= pcfg_d;
      flag_q <= flag_d;
      ie_q   <= ie_d;
      off_q  <= off_d;
    end
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) result_q <= '0;
    else if (done)  result_q <= done_code;
  end

  adc_tick_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_tick (
    .clk(clk), .rst_n(dev_rst_n), .run(run), .sel(cs_q),
    .rc_tick(rc_tick), .tick(tick)
  );

  adc_sar_engine #(.RES_W(RES_W), .HOLD_CLKS(HOLD_CLKS)) u_engine (
    .clk(clk), .rst_n(dev_rst_n), .start(go_req),
    .rc_mode(wr_data[7:6] == CLK_RC), .abort(sleep_kill || user_abort),
    .tick(tick), .cmp_bit(cmp_bit), .run(run), .done(done),
    .done_code(done_code), .dac_code(dac_code)
  );

  adc_result_fmt #(.RES_W(RES_W), .BYTE_W(8)) u_fmt (
    .right_just(just_q), .code(result_q), .hi(res_hi), .lo(res_lo)
  );

  assign ctrl_q   = {cs_q, chs_q, go_q, 1'b0, en_q};
  assign cfg_q    = {just_q, 3'b000, pcfg_q};
  assign irq_q    = {6'b0, ie_q, flag_q};
  assign chan_sel = chs_q;
  assign powered  = en_q && !off_q;
  assign wake     = sleep_req && flag_q && ie_q;

  // R3
  go_needs_en_chk: assert property (@(posedge clk) disable iff (!dev_rst_n)
    !en_q |-> !go_q);
  // R4
  done_flag_chk: assert property (@(posedge clk) disable iff (!dev_rst_n)
    done |=> (!go_q && flag_q));
  // R7
  sleep_kill_chk: assert property (@(posedge clk) disable iff (!dev_rst_n)
    (sleep_kill && !ctrl_wr) |=> (!ctrl_q[2] && !powered && ctrl_q[0]));
  // R9
  rc_sleep_off_chk: assert property (@(posedge clk) disable iff (!dev_rst_n)
    (done && sleep_req && !ie_q && !irq_wr && !ctrl_wr) |=> (!powered && ctrl_q[0]));
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    !done |=> $stable(result_q));
  // R5
  right_pad_chk: assert property (@(posedge clk) disable iff (!dev_rst_n)
    just_q |-> (res_hi >> (RES_W - 8)) == 8'd0);
  // R5
  left_pad_chk: assert property (@(posedge clk) disable iff (!dev_rst_n)
    !just_q |-> res_lo[PAD-1:0] == '0);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic sleep_req = 1'b0, rc_tick = 1'b0, cmp_bit;
  logic [7:0] ctrl_q, cfg_q, irq_q, res_hi, res_lo;
  logic [9:0] dac_code;
  logic [2:0] chan_sel;
  logic powered, wake;

  int vin = 0;
  int vectors = 0, miscompares = 0;
  bit rc_on = 1'b0, cmp_on = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sleep_req(sleep_req), .rc_tick(rc_tick), .cmp_bit(cmp_bit),
    .ctrl_q(ctrl_q), .cfg_q(cfg_q), .irq_q(irq_q), .res_hi(res_hi), .res_lo(res_lo),
    .dac_code(dac_code), .chan_sel(chan_sel), .powered(powered), .wake(wake)
  );

  // ideal comparator: keep the trial bit while the input is not below it
  assign cmp_bit = (vin >= int'(dac_code));

  // RC oscillator: one pulse every third clock
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 3;
      rc_tick = rc_on && (ph == 0);
    end
  end

  // behavioural reference
  int m_cs, m_chs, m_go, m_en, m_just, m_pcfg, m_flag, m_ie, m_off, m_res;
  int m_stage, m_clk, m_dec;

  function automatic int div_of(int cs);
    return (cs == 0) ? 2 : (cs == 1) ? 8 : 32;
  endfunction

  function automatic logic [15:0] layout(int just, int code);
    return just ? 16'(code) : 16'(code << 6);
  endfunction

  task automatic m_clear();
    m_cs = 0; m_chs = 0; m_go = 0; m_en = 0; m_just = 0; m_pcfg = 0;
    m_flag = 0; m_ie = 0; m_off = 0; m_stage = 0; m_clk = 0; m_dec = 0;
  endtask

  initial begin m_clear(); m_res = 0; end

  always @(posedge clk) begin
    if (!por_n) begin
      m_clear(); m_res = 0;
    end else if (!rst_n) begin
      m_clear();
    end else begin
      bit tk, fin, kill, cw, gor, uab;
      int d;
      d    = int'(wr_data);
      tk   = 0;
      if (m_stage >= 2) tk = (m_cs == 3) ? rc_tick : (m_clk + 1 >= div_of(m_cs));
      fin  = (m_stage == 3) && tk && (m_dec == 9);
      kill = sleep_req && m_en && (m_cs != 3);
      cw   = wr_en && (wr_sel == 2'd0);
      gor  = cw && d[2] && d[0] && m_en && !m_off && !m_go && !sleep_req;
      uab  = m_go && cw && !(d[2] && d[0]);
      if (kill || uab) fin = 0;
      if (kill || uab) m_stage = 0;
      else case (m_stage)
        0: if (gor) begin m_stage = ((d >> 6) == 3) ? 1 : 2; m_clk = 0; end
        1: begin m_clk++; if (m_clk == 4) begin m_stage = 2; m_clk = 0; end end
        2: if (tk) begin m_stage = 3; m_dec = 0; m_clk = 0; end else m_clk++;
        default: if (tk) begin
          if (fin) m_stage = 0; else m_dec++;
          m_clk = 0;
        end else m_clk++;
      endcase
      if (fin) m_res = (vin > 1023) ? 1023 : vin;
      if (kill) m_off = 1;
      else if (!sleep_req) m_off = 0;
      else if (fin && !m_ie) m_off = 1;
      if (kill || uab || fin) m_go = 0; else if (gor) m_go = 1;
      if (fin) m_flag = 1; else if (wr_en && wr_sel == 2'd2) m_flag = d & 1;
      if (wr_en && wr_sel == 2'd2) m_ie = (d >> 1) & 1;
      if (cw) begin m_cs = (d >> 6) & 3; m_chs = (d >> 3) & 7; m_en = d & 1; end
      if (wr_en && wr_sel == 2'd1) begin m_just = (d >> 7) & 1; m_pcfg = d & 15; end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      logic [15:0] w;
      w = layout(m_just, m_res);
      chk(cur_req, "ctrl", ctrl_q, (m_cs << 6) | (m_chs << 3) | (m_go << 2) | m_en);
      chk(cur_req, "cfg", cfg_q, (m_just << 7) | m_pcfg);
      chk(cur_req, "irq", irq_q, (m_ie << 1) | m_flag);
      chk(cur_req, "res", {res_hi, res_lo}, w);
      chk(cur_req, "powered", powered, m_en && !m_off);
      chk(cur_req, "wake", wake, sleep_req && m_flag && m_ie);
      chk(cur_req, "chan", chan_sel, m_chs);
    end
  end

  task automatic wr(logic [1:0] sel, logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] keep;
    idle(3);
    por_n = 1'b1; rst_n = 1'b1;
    idle(4);
    cmp_on = 1'b1;
    // R1 reset state
    cur_req = "R1";
    chk("R1", "ctrl", ctrl_q, 0); chk("R1", "cfg", cfg_q, 0);
    chk("R1", "irq", irq_q, 0);   chk("R1", "powered", powered, 0);
    chk("R1", "dac", dac_code, 0);

    // R4 divide-by-2 conversion, right aligned (R5)
    cur_req = "R4";
    wr(2'd1, 8'h80);
    wr(2'd0, 8'h01);
    vin = 'h2A5;
    wr(2'd0, 8'h15);
    idle(28);
    chk("R4", "go clear", ctrl_q[2], 0);
    chk("R4", "flag", irq_q[0], 1);
    chk("R5", "right", {res_hi, res_lo}, 16'h02A5);
    cur_req = "R5";
    wr(2'd1, 8'h00);
    chk("R5", "left", {res_hi, res_lo}, 16'hA940);

    // R4 divide-by-8 and divide-by-32
    cur_req = "R4";
    wr(2'd2, 8'h00);
    vin = 1023;
    wr(2'd0, 8'h45);
    idle(95);
    chk("R4", "div8", {res_hi, res_lo}, 16'hFFC0);
    vin = 0;
    wr(2'd0, 8'h85);
    idle(360);
    chk("R4", "div32", {res_hi, res_lo}, 16'h0000);
    chk("R4", "div32 flag", irq_q[0], 1);

    // R3 go without prior enable
    cur_req = "R3";
    wr(2'd0, 8'h00);
    vin = 'h155;
    wr(2'd0, 8'h05);
    idle(30);
    chk("R3", "go", ctrl_q, 8'h01);
    chk("R3", "res", {res_hi, res_lo}, 16'h0000);

    // R10 user abort
    cur_req = "R10";
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h05);
    idle(5);
    wr(2'd0, 8'h01);
    idle(30);
    chk("R10", "flag", irq_q[0], 0);
    chk("R10", "res", {res_hi, res_lo}, 16'h0000);

    // R7 sleep kills a non-RC conversion
    cur_req = "R7";
    wr(2'd0, 8'h05);
    idle(6);
    sleep_req = 1'b1;
    idle(2);
    chk("R7", "go", ctrl_q[2], 0);
    chk("R7", "en", ctrl_q[0], 1);
    chk("R7", "powered", powered, 0);
    chk("R7", "flag", irq_q[0], 0);
    idle(30);
    chk("R7", "res", {res_hi, res_lo}, 16'h0000);
    sleep_req = 1'b0;
    idle(2);
    chk("R7", "repower", powered, 1);

    // R6/R8 RC conversion through sleep with wake
    cur_req = "R8";
    rc_on = 1'b1;
    vin = 'h3C3;
    wr(2'd1, 8'h80);
    wr(2'd2, 8'h02);
    wr(2'd0, 8'hC1);
    wr(2'd0, 8'hED);
    sleep_req = 1'b1;
    idle(2);
    chk("R6", "held", ctrl_q[2], 1);
    idle(60);
    chk("R8", "wake", wake, 1);
    chk("R8", "powered", powered, 1);
    chk("R8", "res", {res_hi, res_lo}, 16'h03C3);
    sleep_req = 1'b0;
    idle(2);
    chk("R11", "wake low", wake, 0);

    // R9 RC completion in sleep, interrupt disabled
    cur_req = "R9";
    wr(2'd2, 8'h00);
    vin = 'h0F0;
    wr(2'd0, 8'hC5);
    sleep_req = 1'b1;
    idle(60);
    chk("R9", "powered", powered, 0);
    chk("R9", "en", ctrl_q[0], 1);
    chk("R9", "wake", wake, 0);
    chk("R9", "res", {res_hi, res_lo}, 16'h00F0);
    cur_req = "R11";
    wr(2'd2, 8'h03);
    chk("R11", "wake", wake, 1);
    wr(2'd3, 8'hFF);
    chk("R11", "sel3", irq_q, 8'h03);
    sleep_req = 1'b0;
    rc_on = 1'b0;
    idle(2);

    // R2 device reset keeps result, power-on reset clears it
    cur_req = "R2";
    keep = layout(0, 'h0F0);
    @(negedge clk); rst_n = 1'b0;
    idle(3); rst_n = 1'b1;
    idle(4);
    chk("R2", "ctrl", ctrl_q, 0);
    chk("R2", "kept", {res_hi, res_lo}, keep);
    @(negedge clk); por_n = 1'b0;
    idle(3); por_n = 1'b1;
    idle(4);
    chk("R2", "por", {res_hi, res_lo}, 16'h0000);
    chk("R1", "powered", powered, 0);
    idle(2);
    summary();
  end
endmodule